// File: doc/BRIEF.md
# Prescaled PWM Timer with Staged Update

A single-channel pulse-width generator controlled through two 32-bit registers on a simple synchronous register port. The port has a byte address, a write enable, write data and read data. The input clock passes through a power-of-two prescaler. The prescaler advances a 10-bit position counter. Each period lasts a programmed number of prescaled ticks. The output is high for a programmed number of ticks at the start of every period and low for the rest.

Software changes settings without glitches by setting a staging flag first. While that flag is set, new counts and prescale values are only buffered. Clearing the flag commits all of them together: at the next period boundary if the channel runs, or one clock later if it is idle. Any write whose resulting counts contain a zero leaves the channel disabled. A 0% duty output therefore cannot be produced.

Top module: `spwm_timer`

## Requirements
- R1: After reset both registers read zero and `pwm_out` is low.
- R2: Control register (offset 0x00): enable at bit 0, a stored source-select bit at bit 4, staging flag at bit 11, prescale half-step at bit 15, prescale field at bits 19:16. Count register (offset 0x04): period count at bits 25:16, high count at bits 9:0. Reads are combinational. Reads return the latest written (staged) values. Unlisted bits read zero. Other offsets read zero and ignore writes.
- R3: The divide exponent is 2 × field + half-step, limited to 24. The position counter advances once every 2^exponent clocks.
- R4: From the clock after an accepted enable, the output is high for high × 2^exp clocks. It is then low until the period of period × 2^exp clocks ends, and the pattern repeats.
- R5: A high count greater than or equal to the period count keeps the output high all the time.
- R6: An enable write is refused (enable reads 0, output stays low) when the period or high count in force after the write is zero.
- R7: A write with the staging flag clear that makes either active count zero clears the enable and drives the output low.
- R8: While the staging flag is 1, count and prescale writes change only the read-back values. The output timing is unchanged.
- R9: Clearing the staging flag commits the staged values at the next period boundary, which starts a new period, when running. When idle it commits one clock later.
- R10: Clearing enable drives the output low on the next clock. Setting it starts a fresh period with the output high. A write with the staging flag clear that changes active values while running also restarts the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pwm_out | output | 1 | Active-high PWM output |

## Verification
A vector table tries exponents 0 to 4, using both the field and the half-step bit. Odd exponents use the half-step bit and even exponents use the field, so a swapped weight shows up in the measured widths. Short and long periods separate an off-by-one in the wrap from one in the high-time compare. Equal and oversized high counts show the always-high case. Directed runs stage a new setting while an old one runs, which tells an immediate load apart from one held to the boundary. Further runs zero each count in turn, to show that the enable is refused and that a running channel drops out.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
   localparam int REG_W    = 32;
   localparam int CNT_W    = 10;
   localparam int PRE_W    = 4;
   localparam int EXP_W    = PRE_W + 1;

   localparam int CTRL_OFS = 0;
   localparam int CNT_OFS  = 4;

   // bit positions decoded by software
   localparam int EN_BIT   = 0;
   localparam int SRC_BIT  = 4;
   localparam int SYNC_BIT = 11;
   localparam int HALF_BIT = 15;
   localparam int PRE_LSB  = 16;
   localparam int CYC_LSB  = 16;
   localparam int PH_LSB   = 0;

   typedef struct packed {
      logic [PRE_W-1:0] pre;
      logic             half;
      logic [CNT_W-1:0] cyc;
      logic [CNT_W-1:0] ph;
   } cfg_t;
endpackage

// File: rtl/spwm_regs.sv
module spwm_regs
   import spwm_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [REG_W-1:0]  wdata,
   output logic [REG_W-1:0]  rdata,
   input  logic              boundary,
   output logic              en_o,
   output logic              en_next_o,
   output logic              restart_o,
   output cfg_t              act_o
);
   logic en_q, src_q, sync_q, pend_q;
   cfg_t shd_q, shd_d, act_q, act_d;
   logic wr_ctrl, wr_cnt, sync_fall, direct, commit, load, en_d, pend_d;

   assign wr_ctrl = we && (addr == ADDR_W'(CTRL_OFS));
   assign wr_cnt  = we && (addr == ADDR_W'(CNT_OFS));

   always_comb begin
      shd_d = shd_q;
      if (wr_ctrl) begin
         shd_d.pre  = wdata[PRE_LSB +: PRE_W];
         shd_d.half = wdata[HALF_BIT];
      end
      if (wr_cnt) begin
         shd_d.cyc = wdata[CYC_LSB +: CNT_W];
         shd_d.ph  = wdata[PH_LSB +: CNT_W];
      end
   end

   assign sync_fall = wr_ctrl && sync_q && !wdata[SYNC_BIT];
   assign direct    = (wr_ctrl || wr_cnt) && !sync_q;
   assign commit    = pend_q && (!en_q || boundary);
   assign load      = direct || commit;
   assign act_d     = load ? shd_d : act_q;

   // enable survives only with both counts in force non-zero
   assign en_d   = (wr_ctrl ? wdata[EN_BIT] : en_q)
                   && (act_d.cyc != '0) && (act_d.ph != '0);
   assign pend_d = sync_fall ? 1'b1 : (load ? 1'b0 : pend_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         src_q  <= 1'b0;
         sync_q <= 1'b0;
         pend_q <= 1'b0;
         shd_q  <= '0;
         act_q  <= '0;
      end else begin
         en_q   <= en_d;
         pend_q <= pend_d;
         shd_q  <= shd_d;
         act_q  <= act_d;
         if (wr_ctrl) begin
            src_q  <= wdata[SRC_BIT];
            sync_q <= wdata[SYNC_BIT];
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(CTRL_OFS)) begin
         rdata[EN_BIT]               = en_q;
         rdata[SRC_BIT]              = src_q;
         rdata[SYNC_BIT]             = sync_q;
         rdata[HALF_BIT]             = shd_q.half;
         rdata[PRE_LSB +: PRE_W]     = shd_q.pre;
      end else if (addr == ADDR_W'(CNT_OFS)) begin
         rdata[CYC_LSB +: CNT_W]     = shd_q.cyc;
         rdata[PH_LSB +: CNT_W]      = shd_q.ph;
      end
   end

   assign en_o      = en_q;
   assign en_next_o = en_d;
   assign restart_o = en_d && (!en_q || load);
   assign act_o     = act_q;

   logic unused_wdata;
   assign unused_wdata = ^{wdata[REG_W-1:CYC_LSB+CNT_W], wdata[CYC_LSB-1:PH_LSB+CNT_W]};

   AST_EN_NEEDS_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |-> (act_q.cyc != '0 && act_q.ph != '0)); // R6
   AST_SYNC_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_q && !pend_q) |=> $stable(act_q)); // R8
   AST_PEND_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !en_q && !we) |=> !pend_q); // R9
endmodule

// File: rtl/spwm_prescaler.sv
module spwm_prescaler
   import spwm_pkg::*;
#(
   parameter int MAX_EXP = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic [EXP_W-1:0] exp_in,
   output logic             tick
);
   logic [EXP_W-1:0] exp_eff;
   assign exp_eff = (exp_in > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : exp_in;

   generate
      if (MAX_EXP == 0) begin : g_nodiv
         assign tick = run;
         logic unused_ctl;
         assign unused_ctl = ^{clk, rst_n, clr, exp_eff};
      end else begin : g_div
         logic [MAX_EXP-1:0] cnt_q;
         logic [MAX_EXP:0]   full;
         logic [MAX_EXP-1:0] mask;
         assign full = ((MAX_EXP+1)'(1) << exp_eff) - (MAX_EXP+1)'(1);
         assign mask = full[MAX_EXP-1:0];
         assign tick = run && ((cnt_q & mask) == mask);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cnt_q <= '0;
            else if (clr)    cnt_q <= '0;
            else if (run)    cnt_q <= cnt_q + 1'b1;
         end

         AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
            (tick && exp_eff != '0 && !clr) |=> !tick); // R3
      end
   endgenerate
endmodule

// File: rtl/spwm_wave.sv
module spwm_wave
   import spwm_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] cyc,
   input  logic [CNT_W-1:0] ph,
   output logic             boundary,
   output logic             pwm_out
);
   logic [CNT_W-1:0] pos_q;

   assign boundary = run && tick && (pos_q == cyc - 1'b1);
   assign pwm_out  = run && (pos_q < ph);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pos_q <= '0;
      else if (clr)       pos_q <= '0;
      else if (tick)      pos_q <= boundary ? '0 : pos_q + 1'b1;
   end

   AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (pos_q < cyc)); // R4
   AST_POS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (pos_q == '0)); // R10
endmodule

// File: rtl/spwm_timer.sv
module spwm_timer
   import spwm_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int MAX_EXP = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic [REG_W-1:0]  bus_rdata,
   output logic              pwm_out
);
   generate
      if (ADDR_W < 3) begin : g_bad_addr
         $error("ADDR_W must reach offset 0x04");
      end
      if (MAX_EXP < 0 || MAX_EXP > 31) begin : g_bad_exp
         $error("MAX_EXP must lie in 0..31");
      end
   endgenerate

   logic en, en_next, restart, boundary, tick, clr;
   cfg_t act;

   spwm_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we),
      .wdata(bus_wdata), .rdata(bus_rdata), .boundary(boundary),
      .en_o(en), .en_next_o(en_next), .restart_o(restart), .act_o(act)
   );

   assign clr = restart || !en_next;

   spwm_prescaler #(.MAX_EXP(MAX_EXP)) u_pre (
      .clk(clk), .rst_n(rst_n), .clr(clr), .run(en),
      .exp_in({act.pre, act.half}), .tick(tick)
   );

   spwm_wave u_wave (
      .clk(clk), .rst_n(rst_n), .clr(clr), .run(en), .tick(tick),
      .cyc(act.cyc), .ph(act.ph), .boundary(boundary), .pwm_out(pwm_out)
   );
endmodule

// File: tb/spwm_timer_test.sv
`timescale 1ns/1ps
module spwm_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        pwm_out;
   int          n_run = 0;
   int          n_fail = 0;

   localparam logic [31:0] ENB = 32'h1, SYN = 32'h800;
   localparam int NV = 7;
   // stimulus: prescale field, half-step, period count, high count
   localparam int V_PRE [NV] = '{0, 0, 1, 1, 2, 0, 0};
   localparam int V_HALF[NV] = '{0, 1, 0, 1, 0, 0, 1};
   localparam int V_CYC [NV] = '{4, 5, 3, 6, 3, 3, 2};
   localparam int V_PH  [NV] = '{1, 2, 2, 3, 1, 3, 7};

   always #2.5 clk = ~clk;

   spwm_timer uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
                   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #0.1;
      d = bus_rdata;
   endtask

   task automatic count_level(input logic lvl, output int n);
      n = 0;
      while (pwm_out === lvl && n < 5000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic wait_rise();
      int k;
      k = 0;
      while (pwm_out && k < 5000) begin k++; @(negedge clk); end
      while (!pwm_out && k < 10000) begin k++; @(negedge clk); end
   endtask

   initial begin
      #1000000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] d;
      int hi, lo, e, cfg;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(8'h00, d); chk(d == 0, "R1 ctrl after reset", d, 0);
      rd(8'h04, d); chk(d == 0, "R1 count after reset", d, 0);
      chk(pwm_out == 1'b0, "R1 output after reset", pwm_out, 0);

      // R2 / R6 all-ones control write, counts still zero
      wr(8'h00, 32'hFFFF_FFFF);
      rd(8'h00, d); chk(d == 32'h000F_8810, "R2 R6 ctrl readback", d, 32'h000F_8810);
      wr(8'h00, 32'h0);
      rd(8'h00, d); chk(d == 0, "R2 ctrl cleared", d, 0);
      wr(8'h08, 32'hFFFF_FFFF);
      rd(8'h08, d); chk(d == 0, "R2 unmapped read", d, 0);
      rd(8'h00, d); chk(d == 0, "R2 unmapped write ignored", d, 0);

      // R6 zero high count refuses enable
      wr(8'h04, (32'd5 << 16));
      wr(8'h00, ENB);
      rd(8'h00, d); chk(d[0] == 1'b0, "R6 enable refused ph=0", d[0], 0);
      repeat (4) @(negedge clk);
      chk(pwm_out == 1'b0, "R6 output low ph=0", pwm_out, 0);
      wr(8'h04, 32'd5);
      wr(8'h00, ENB);
      rd(8'h00, d); chk(d[0] == 1'b0, "R6 enable refused cyc=0", d[0], 0);
      rd(8'h04, d); chk(d == 32'd5, "R2 count readback", d, 5);

      // R3 R4 R5 vector table
      for (int i = 0; i < NV; i++) begin
         e   = 2 * V_PRE[i] + V_HALF[i];
         cfg = (V_PRE[i] << 16) | (V_HALF[i] << 15);
         wr(8'h00, 32'h0);
         wr(8'h00, SYN);
         wr(8'h04, (V_CYC[i] << 16) | V_PH[i]);
         wr(8'h00, SYN | cfg);
         wr(8'h00, cfg);
         wr(8'h00, cfg | ENB);
         if (V_PH[i] >= V_CYC[i]) begin
            count_level(1'b1, hi);
            chk(hi >= 2 * (V_CYC[i] << e), $sformatf("R5 vec%0d always high", i),
                hi, 2 * (V_CYC[i] << e));
         end else begin
            count_level(1'b1, hi);
            count_level(1'b0, lo);
            chk(hi == (V_PH[i] << e), $sformatf("R3 R4 vec%0d high clocks", i),
                hi, V_PH[i] << e);
            chk(lo == ((V_CYC[i] - V_PH[i]) << e), $sformatf("R3 R4 vec%0d low clocks", i),
                lo, (V_CYC[i] - V_PH[i]) << e);
         end
      end

      // R8 R9 staged change while running (cyc 4, ph 1, exp 0)
      wr(8'h00, 32'h0);
      wr(8'h04, (32'd4 << 16) | 32'd1);
      wr(8'h00, ENB);
      wr(8'h00, SYN | ENB);
      wr(8'h04, (32'd8 << 16) | 32'd4);
      rd(8'h04, d); chk(d == 32'h0008_0004, "R8 staged readback", d, 32'h0008_0004);
      wait_rise();
      count_level(1'b1, hi); count_level(1'b0, lo);
      chk(hi == 1, "R8 old high kept", hi, 1);
      chk(lo == 3, "R8 old low kept", lo, 3);
      wr(8'h00, ENB);
      wait_rise();
      count_level(1'b1, hi); count_level(1'b0, lo);
      chk(hi == 4, "R9 committed high", hi, 4);
      chk(lo == 4, "R9 committed low", lo, 4);

      // R10 disable and restart
      wr(8'h00, 32'h0);
      chk(pwm_out == 1'b0, "R10 low after disable", pwm_out, 0);
      repeat (10) @(negedge clk);
      chk(pwm_out == 1'b0, "R10 stays low", pwm_out, 0);
      wr(8'h00, ENB);
      chk(pwm_out == 1'b1, "R10 high on start", pwm_out, 1);
      count_level(1'b1, hi);
      chk(hi == 4, "R10 fresh period high", hi, 4);

      // R7 zero count while running drops enable
      wr(8'h04, 32'd5);
      rd(8'h00, d); chk(d[0] == 1'b0, "R7 enable cleared", d[0], 0);
      chk(pwm_out == 1'b0, "R7 output low", pwm_out, 0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule